// File: doc/BRIEF.md
# LIN Wake-up and Resync Controller

This block is the control core of a LIN protocol engine for three tasks. It sends a bus wake-up. It waits for a programmable delimiter after the wake-up. It returns the engine to its start state. Software writes an 8-bit control word. A one-shot field in that word asks for a wake-up. The block then pulls the transmit line dominant (low) for eight bit times. It releases the line and counts a delimiter of 4, 8, 32 or 64 bit times. Only after the delimiter does it raise `tx_ready`. All timing is counted on a one-cycle bit-time tick, `bit_tick`, that comes from outside the block.

The engine start state is shown on `eng_rst`. This output stays high for as long as the resync field is held at 1. It also pulses for one cycle after any exception (a bit error, a physical bus error or a received wake-up flag), unless the debug field is set. In debug mode the engine keeps running through exceptions. A sticky `exc_pending` flag records every exception until software clears it. With the enable field at 0 the block is silent.

The controller is one state machine. Its states are OFF, READY, WAKE, DELIM, RESYNC and RESTART. Its transitions are listed here:
- Any state goes to OFF when enable is 0.
- Any enabled state goes to RESYNC while resync is 1.
- Any enabled state goes to RESTART on an exception when debug is 0.
- OFF, RESYNC and RESTART go to READY.
- READY goes to WAKE on a wake-up request.
- WAKE goes to DELIM on the eighth tick.
- DELIM goes to READY on the last delimiter tick.

The priority order is disable, then resync, then exception, then normal flow.

Top module: `lin_wake_ctrl`

## Requirements
- R1: The control word uses these bit positions: bit 0 wake request, bits 2:1 delimiter select, bit 3 resync, bit 4 debug, bit 5 enable. `ctl_rdata` returns the stored fields at the same positions. Bit 0 always reads 0, and bits 7:6 read 0.
- R2: A wake request written while the block is READY drives `lin_tx` low for exactly 8 bit ticks. The line then goes back high.
- R3: After the wake-up pulse, `tx_ready` stays low for a further 4, 8, 32 or 64 bit ticks, for select values 00, 01, 10 and 11 in that order. It then goes high.
- R4: A wake request that arrives during the wake-up pulse or the delimiter is dropped. It does not lengthen or restart either count.
- R5: While resync is 1 and enable is 1, `eng_rst` is high, `tx_ready` is low and `lin_tx` is high. Setting resync aborts a wake-up in progress. Clearing resync brings `tx_ready` back high.
- R6: With debug at 0, an exception drives `eng_rst` high for exactly one cycle and aborts any wake-up or delimiter in progress. After that cycle `tx_ready` returns high.
- R7: With debug at 1, an exception leaves `eng_rst` low and does not disturb `tx_ready` or a wake-up sequence in progress.
- R8: `exc_pending` is set by any exception while the block is enabled. It stays set until `exc_clr` is pulsed.
- R9: With enable at 0, `tx_ready` is low and `lin_tx` is high. Wake requests are ignored, and exceptions do not set `exc_pending`.
- R10: After reset, `tx_ready` is 0, `lin_tx` is 1, `eng_rst` is 0 and `exc_pending` is 0. With enable at 1 and nothing in progress, `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per LIN bit time |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word write data |
| ctl_rdata | output | 8 | Control word readback |
| bit_err | input | 1 | Bit error exception |
| bus_err | input | 1 | Physical bus error exception |
| wake_rx | input | 1 | Received wake-up flag exception |
| exc_clr | input | 1 | Clears the sticky exception flag |
| lin_tx | output | 1 | LIN transmit line, 0 = dominant |
| tx_ready | output | 1 | A new frame may start |
| eng_rst | output | 1 | Engine held in or returned to its start state |
| exc_pending | output | 1 | Sticky exception flag |

## Verification
Suppose the state or the bit counter is wrong. The ports then show a dominant pulse or a gap before `tx_ready` that is the wrong number of ticks long. The scoreboard catches this on the first `tx_ready` rise after the request. Suppose instead that the priority order is broken. Then `eng_rst` or `lin_tx` shows a wrong value in the cycle right after resync, an exception or disable takes effect, and the bench samples exactly that cycle.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;
    localparam int unsigned CW_W   = 8;
    localparam int unsigned B_WAKE = 0;
    localparam int unsigned B_SEL  = 1;
    localparam int unsigned B_RS   = 3;
    localparam int unsigned B_DBG  = 4;
    localparam int unsigned B_EN   = 5;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_READY,
        ST_WAKE,
        ST_DELIM,
        ST_RESYNC,
        ST_RESTART
    } lw_state_e;
endpackage

// File: rtl/lin_bit_counter.sv
module lin_bit_counter #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/lin_exc_flag.sv
module lin_exc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> flag);
endmodule

// File: rtl/lin_wake_ctrl.sv
module lin_wake_ctrl
    import lin_wake_pkg::*;
#(
    parameter int unsigned WAKE_BITS = 8,
    parameter int unsigned DLM0      = 4,
    parameter int unsigned DLM1      = 8,
    parameter int unsigned DLM2      = 32,
    parameter int unsigned DLM3      = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_tick,
    input  logic            ctl_we,
    input  logic [CW_W-1:0] ctl_wdata,
    output logic [CW_W-1:0] ctl_rdata,
    input  logic            bit_err,
    input  logic            bus_err,
    input  logic            wake_rx,
    input  logic            exc_clr,
    output logic            lin_tx,
    output logic            tx_ready,
    output logic            eng_rst,
    output logic            exc_pending
);
    localparam int unsigned MAXC  = (DLM3 > WAKE_BITS) ? DLM3 : WAKE_BITS;
    localparam int unsigned CNT_W = $clog2(MAXC + 1);

    logic       en_q, rs_q, dbg_q, wake_pend_q;
    logic [1:0] sel_q, dsel_q;
    lw_state_e  state_q, state_d;
    logic [CNT_W-1:0] cnt, lim;
    logic       cnt_clr, exc_any;

    assign exc_any = bit_err | bus_err | wake_rx;

    // control word register; the wake field is a one-cycle request only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; rs_q <= 1'b0; dbg_q <= 1'b0;
            sel_q <= 2'b00; wake_pend_q <= 1'b0;
        end else begin
            wake_pend_q <= ctl_we & ctl_wdata[B_WAKE];
            if (ctl_we) begin
                en_q  <= ctl_wdata[B_EN];
                rs_q  <= ctl_wdata[B_RS];
                dbg_q <= ctl_wdata[B_DBG];
                sel_q <= ctl_wdata[B_SEL +: 2];
            end
        end
    end

    always_comb begin
        ctl_rdata        = '0;
        ctl_rdata[B_EN]  = en_q;
        ctl_rdata[B_RS]  = rs_q;
        ctl_rdata[B_DBG] = dbg_q;
        ctl_rdata[B_SEL +: 2] = sel_q;
    end

    always_comb begin
        unique case (dsel_q)
            2'b00:   lim = CNT_W'(DLM0);
            2'b01:   lim = CNT_W'(DLM1);
            2'b10:   lim = CNT_W'(DLM2);
            default: lim = CNT_W'(DLM3);
        endcase
    end

    // next-state logic: disable > resync > exception > normal flow
    always_comb begin
        state_d = state_q;
        if (!en_q)                  state_d = ST_OFF;
        else if (rs_q)              state_d = ST_RESYNC;
        else if (exc_any && !dbg_q) state_d = ST_RESTART;
        else begin
            unique case (state_q)
                ST_OFF, ST_RESYNC, ST_RESTART: state_d = ST_READY;
                ST_READY: if (wake_pend_q) state_d = ST_WAKE;
                ST_WAKE:  if (bit_tick && cnt == CNT_W'(WAKE_BITS - 1)) state_d = ST_DELIM;
                ST_DELIM: if (bit_tick && cnt == lim - 1'b1) state_d = ST_READY;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            dsel_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            if (state_d == ST_WAKE && state_q != ST_WAKE) dsel_q <= sel_q;
        end
    end

    assign cnt_clr = (state_d != state_q) ||
                     !(state_q == ST_WAKE || state_q == ST_DELIM);

    lin_bit_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(bit_tick), .cnt(cnt)
    );

    lin_exc_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(en_q & exc_any), .clr(exc_clr),
        .flag(exc_pending)
    );

    // outputs
    always_comb begin
        lin_tx   = 1'b1;
        tx_ready = 1'b0;
        eng_rst  = 1'b0;
        unique case (state_q)
            ST_READY:   tx_ready = en_q & ~rs_q;
            ST_WAKE:    lin_tx   = 1'b0;
            ST_RESYNC,
            ST_RESTART: eng_rst  = 1'b1;
            default: ;
        endcase
    end

    // R2
    ready_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> lin_tx);
    // R2
    wake_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_WAKE |-> cnt < CNT_W'(WAKE_BITS));
    // R3
    dlm_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DELIM |-> cnt < lim);
    // R5
    rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && rs_q && $past(en_q) && $past(rs_q) |-> eng_rst && !tx_ready && lin_tx);
    // R6
    restart_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_RESTART && !exc_any |=> state_q != ST_RESTART);
    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_OFF |-> lin_tx && !tx_ready && !eng_rst);
endmodule

// File: tb/sim_lin_wake_ctrl.sv
`timescale 1ns/1ps
module sim_lin_wake_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic [7:0] ctl_rdata;
    logic bit_err = 1'b0, bus_err = 1'b0, wake_rx = 1'b0, exc_clr = 1'b0;
    logic lin_tx, tx_ready, eng_rst, exc_pending;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam logic [7:0] K_WAKE = 8'h01, K_RS = 8'h08, K_DBG = 8'h10, K_EN = 8'h20;

    always #10 clk = ~clk;

    lin_wake_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .bit_err(bit_err),
        .bus_err(bus_err), .wake_rx(wake_rx), .exc_clr(exc_clr),
        .lin_tx(lin_tx), .tx_ready(tx_ready), .eng_rst(eng_rst),
        .exc_pending(exc_pending)
    );

    // bit tick every third clock
    int tdiv = 0;
    always @(posedge clk) begin
        #1;
        tdiv = (tdiv + 1) % 3;
        bit_tick <= (tdiv == 0);
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard queues: expected wake-up length and delimiter length
    int exp_wk_q[$];
    int exp_dl_q[$];
    string exp_req_q[$];

    task automatic push_seq(input int dl, input string req);
        exp_wk_q.push_back(8);
        exp_dl_q.push_back(dl);
        exp_req_q.push_back(req);
    endtask

    // monitor: measures pulse and delimiter in ticks
    int ph = 0, wk = 0, dl = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (eng_rst) begin
                ph = 0; wk = 0; dl = 0;
            end else begin
                case (ph)
                    0: if (!lin_tx) begin ph = 1; wk = bit_tick ? 1 : 0; end
                    1: if (lin_tx) begin ph = 2; dl = bit_tick ? 1 : 0; end
                       else if (bit_tick) wk++;
                    2: if (tx_ready) begin
                           if (exp_wk_q.size() == 0) begin
                               check("R4 unexpected sequence", 1, 0);
                           end else begin
                               string r;
                               int ew, ed;
                               ew = exp_wk_q.pop_front();
                               ed = exp_dl_q.pop_front();
                               r  = exp_req_q.pop_front();
                               check({"R2 pulse ticks ", r}, wk, ew);
                               check({"R3 delimiter ticks ", r}, dl, ed);
                           end
                           ph = 0;
                       end else if (bit_tick) dl++;
                    default: ph = 0;
                endcase
            end
        end
    end

    task automatic wr(input logic [7:0] w);
        @(posedge clk); #1;
        ctl_we = 1'b1; ctl_wdata = w;
        @(posedge clk); #1;
        ctl_we = 1'b0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_ready(input string req);
        int n = 0;
        while (!tx_ready && n < 2000) begin
            @(negedge clk); n++;
        end
        check({req, " tx_ready returns"}, tx_ready, 1);
    endtask

    task automatic pulse_exc(input int which);
        @(posedge clk); #1;
        case (which)
            0: bit_err = 1'b1;
            1: bus_err = 1'b1;
            default: wake_rx = 1'b1;
        endcase
        @(posedge clk); #1;
        bit_err = 1'b0; bus_err = 1'b0; wake_rx = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 tx_ready reset", tx_ready, 0);
        check("R10 lin_tx reset", lin_tx, 1);
        check("R10 eng_rst reset", eng_rst, 0);
        check("R10 exc_pending reset", exc_pending, 0);
        rst_n = 1'b1;

        // R10 idle enabled
        wr(K_EN); settle();
        check("R10 ready when enabled", tx_ready, 1);
        check("R1 readback", ctl_rdata, 8'h20);

        // R1 / R2 / R3 each select value
        for (int s = 0; s < 4; s++) begin
            int dlen;
            dlen = (s == 0) ? 4 : (s == 1) ? 8 : (s == 2) ? 32 : 64;
            push_seq(dlen, "select");
            wr(K_EN | K_WAKE | 8'(s << 1));
            check("R1 wake bit reads 0", ctl_rdata, 8'h20 | 8'(s << 1));
            settle();
            check("R3 not ready during wake", tx_ready, 0);
            wait_ready("R3");
            repeat (5) @(negedge clk);
        end

        // R4 repeated requests ignored
        push_seq(8, "R4 repeat");
        wr(K_EN | K_WAKE | 8'h02);
        repeat (10) @(negedge clk);
        wr(K_EN | K_WAKE | 8'h02);
        repeat (30) @(negedge clk);
        wr(K_EN | K_WAKE | 8'h02);
        wait_ready("R4");
        repeat (5) @(negedge clk);
        check("R4 no extra sequence", exp_wk_q.size(), 0);

        // R9 disabled: wake ignored, exception ignored
        wr(K_WAKE); settle();
        begin
            int lows = 0, rdy = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (!lin_tx) lows++;
                if (tx_ready) rdy++;
            end
            check("R9 line stays recessive", lows, 0);
            check("R9 tx_ready held low", rdy, 0);
        end
        pulse_exc(0); settle();
        check("R9 exception ignored", exc_pending, 0);

        // R5 resync aborts a wake-up
        wr(K_EN); settle();
        wr(K_EN | K_WAKE | 8'h04);
        repeat (8) @(negedge clk);
        check("R5 wake in progress", lin_tx, 0);
        wr(K_EN | K_RS | 8'h04); settle();
        check("R5 eng_rst held", eng_rst, 1);
        check("R5 line released", lin_tx, 1);
        check("R5 tx_ready low", tx_ready, 0);
        repeat (20) @(negedge clk);
        check("R5 still held", eng_rst, 1);
        wr(K_EN | 8'h04); settle();
        check("R5 eng_rst released", eng_rst, 0);
        check("R5 ready after clear", tx_ready, 1);
        repeat (250) @(negedge clk);
        check("R5 aborted sequence stays gone", lin_tx, 1);

        // R6 exception in READY, debug off
        pulse_exc(0);
        @(negedge clk);
        check("R6 restart pulse", eng_rst, 1);
        check("R6 not ready in restart", tx_ready, 0);
        check("R8 flag set", exc_pending, 1);
        @(negedge clk);
        check("R6 pulse is one cycle", eng_rst, 0);
        check("R6 ready again", tx_ready, 1);
        // R8 clear
        @(posedge clk); #1 exc_clr = 1'b1;
        @(posedge clk); #1 exc_clr = 1'b0;
        @(negedge clk);
        check("R8 flag cleared", exc_pending, 0);

        // R6 exception aborts wake-up
        wr(K_EN | K_WAKE | 8'h02);
        repeat (6) @(negedge clk);
        pulse_exc(1);
        @(negedge clk);
        check("R6 restart during wake", eng_rst, 1);
        check("R6 line released", lin_tx, 1);
        @(negedge clk);
        check("R6 ready after abort", tx_ready, 1);
        repeat (80) @(negedge clk);
        check("R6 aborted wake stays gone", lin_tx, 1);

        // R7 debug mode
        wr(K_EN | K_DBG); settle();
        @(posedge clk); #1 exc_clr = 1'b1;
        @(posedge clk); #1 exc_clr = 1'b0;
        pulse_exc(2);
        @(negedge clk);
        check("R7 no restart in debug", eng_rst, 0);
        check("R7 still ready", tx_ready, 1);
        check("R8 flag set in debug", exc_pending, 1);
        push_seq(4, "R7 debug");
        wr(K_EN | K_DBG | K_WAKE);
        repeat (8) @(negedge clk);
        pulse_exc(0);
        @(negedge clk);
        check("R7 wake continues", lin_tx, 0);
        check("R7 eng_rst low", eng_rst, 0);
        wait_ready("R7");
        repeat (20) @(negedge clk);
        check("R8 flag held until cleared", exc_pending, 1);
        check("R7 all sequences seen", exp_wk_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule